// File: doc/BRIEF.md
# Per-Port Frame Statistics Bank With Clear-On-Read

This block keeps the frame and byte statistics of a six-port switch. Each port's receive and transmit MAC paths pulse one strobe per counted event: a frame in a given size bucket, a broadcast, a multicast or pause frame, a checksum, alignment or length fault, an overflow, a drop by filtering, a transmit underrun, one of several collision and deferral outcomes, and the byte totals of good receive frames, bad receive frames and transmitted frames. Every counter is held in flops and is brought out over a simple 32-bit read bus. Each port owns one 256-byte page of that bus.

A read returns the counter's value one cycle later and clears the counter in the same edge. Software therefore only sees the increments since its previous read, and it keeps the running totals itself. The three byte totals are twice as wide as the frame counters and appear as a low word and a high word. Reading the low word freezes the matching high word in a holding register, so a low/high pair read in that order always belongs to the same instant. Counters stop at all-ones instead of wrapping.

Top module: `stat_bank`

## Requirements
- R1: Port n (0..NUM_PORTS-1) owns the page starting at byte address 0x20000 + n*0x100. Event index e (0..38) on `evt_i` bit n*39+e is counted in the word at byte offset 4*(e + [e>15] + [e>16] + [e>31]) of that page. Events 15, 16 and 31 are the wide byte totals (good receive bytes, bad receive bytes, transmitted bytes), and each one's upper half is the word directly above its lower half, at offsets 0x40, 0x48 and 0x88.
- R2: `rd_valid_o` is high exactly in the cycle after a cycle with `rd_en_i` high. `rd_data_o` carries the read value in that cycle and is zero whenever `rd_valid_o` is low.
- R3: Each cycle in which a non-byte event strobe is high adds one to that port's counter for that event.
- R4: A strobe on event 15 or 16 adds that port's `rx_len_i` to the counter, and a strobe on event 31 adds that port's `tx_len_i`. These counters are 2*CNT_W bits wide, and the low word read returns bits CNT_W-1:0.
- R5: A read of a frame counter or of a byte total's low word clears the whole counter. A second read with no event in between returns zero.
- R6: When a read and a strobe hit the same counter in one cycle, the read returns the value before the strobe, and the counter then holds only that strobe's amount (1, or the length for a byte total).
- R7: Counters saturate at all-ones (CNT_W bits for frame counters, 2*CNT_W bits for byte totals) and never wrap.
- R8: A low-word read of a byte total copies the counter's upper half into a holding word. A high-word read returns that holding word (zero after reset), and it neither clears nor changes any counter.
- R9: A read of an address that is misaligned, lies outside the mapped pages, or lies above offset 0xa4 in a page returns zero and changes no counter.
- R10: After reset every counter and holding word is zero and `rd_valid_o` is low.
- R11: A strobe on one port changes no counter of any other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_PORTS*39 | Event strobes, 39 per port, port n at bits n*39 up to n*39+38 |
| rx_len_i | input | NUM_PORTS*LEN_W | Receive frame byte length per port, added on events 15 and 16 |
| tx_len_i | input | NUM_PORTS*LEN_W | Transmit frame byte length per port, added on event 31 |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | DATA_W | Read data, zero-extended counter word |

## Verification
The clearing read and an event strobe can land on the same counter in the same cycle. The bench provokes this on purpose: it holds a strobe high while it reads that counter. It also lets a random stream of strobes and reads collide across all ports. A reference model applies the clear first and the increment second. It expects the read to return the old value and the counter to restart at the strobe's amount, and the follow-up read confirms that restart. A further collision comes from reading a low word: the high-word holding register is then updated in the same edge, and the bench checks that a later high-word read returns the value frozen at that low-word read.

// File: rtl/stat_pkg.sv
package stat_pkg;

  localparam int NUM_EVT   = 39;
  localparam int NUM_WORDS = 42;
  localparam int NUM_WIDE  = 3;

  localparam int EV_RX_GOOD_BYTES = 15;
  localparam int EV_RX_BAD_BYTES  = 16;
  localparam int EV_TX_BYTES      = 31;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_PLAIN = 2'd1,
    WK_LOW   = 2'd2,
    WK_HIGH  = 2'd3
  } word_kind_e;

  function automatic bit evt_is_wide(input int e);
    return (e == EV_RX_GOOD_BYTES) || (e == EV_RX_BAD_BYTES) || (e == EV_TX_BYTES);
  endfunction

  function automatic int wide_slot(input int e);
    if (e == EV_RX_GOOD_BYTES) return 0;
    if (e == EV_RX_BAD_BYTES)  return 1;
    return 2;
  endfunction

  function automatic int slot_evt(input int s);
    if (s == 0) return EV_RX_GOOD_BYTES;
    if (s == 1) return EV_RX_BAD_BYTES;
    return EV_TX_BYTES;
  endfunction

  // word index holding the upper half of a byte total
  function automatic bit word_is_high(input int w);
    return (w == EV_RX_GOOD_BYTES + 1) || (w == EV_RX_BAD_BYTES + 2) ||
           (w == EV_TX_BYTES + 3);
  endfunction

  function automatic int high_slot(input int w);
    if (w == EV_RX_GOOD_BYTES + 1) return 0;
    if (w == EV_RX_BAD_BYTES + 2)  return 1;
    return 2;
  endfunction

  // event index of a non-high word
  function automatic int word_evt(input int w);
    int r;
    r = w;
    if (w > EV_RX_GOOD_BYTES + 1) r = r - 1;
    if (w > EV_RX_BAD_BYTES + 2)  r = r - 1;
    if (w > EV_TX_BYTES + 3)      r = r - 1;
    return r;
  endfunction

endpackage

// File: rtl/stat_addr_dec.sv
module stat_addr_dec #(
  parameter int ADDR_W    = 18,
  parameter int BASE_PAGE = 'h200,
  parameter int NUM_PORTS = 6,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int PAGE_W   = ADDR_W - 8
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit,
  output logic [PORT_W-1:0]     port,
  output logic [5:0]            word,
  output stat_pkg::word_kind_e  kind
);
  import stat_pkg::*;

  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] rel;
  logic              in_pages;

  always_comb begin
    page     = addr[ADDR_W-1:8];
    rel      = page - PAGE_W'(BASE_PAGE);
    in_pages = (page >= PAGE_W'(BASE_PAGE)) && (rel < PAGE_W'(NUM_PORTS));
    word     = addr[7:2];
    hit      = (addr[1:0] == 2'b00) && in_pages && (word < 6'(NUM_WORDS));
    port     = rel[PORT_W-1:0];
    if (!hit)
      kind = WK_NONE;
    else if (word_is_high(int'(word)))
      kind = WK_HIGH;
    else if (evt_is_wide(word_evt(int'(word))))
      kind = WK_LOW;
    else
      kind = WK_PLAIN;
  end

endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W     = 32,
  parameter int AMT_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     cnt
);
  logic [W-1:0] base;
  logic [W:0]   sum;
  logic [W-1:0] nxt;

  always_comb begin
    base = clr ? '0 : cnt;
    sum  = {1'b0, base} + (W+1)'(amt);
    if (!inc)
      nxt = base;
    else if (sum[W])
      nxt = '1;
    else
      nxt = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= nxt;
  end

endmodule

// File: rtl/stat_port_bank.sv
module stat_port_bank #(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [stat_pkg::NUM_EVT-1:0]  evt,
  input  logic [LEN_W-1:0]              rx_len,
  input  logic [LEN_W-1:0]              tx_len,
  input  logic                          sel,
  input  logic [5:0]                    word,
  input  stat_pkg::word_kind_e          kind,
  output logic [DATA_W-1:0]             rd_word
);
  import stat_pkg::*;

  logic [CNT_W-1:0]   lo_val  [NUM_EVT];
  logic [CNT_W-1:0]   wide_hi [NUM_WIDE];
  logic [CNT_W-1:0]   hi_lat  [NUM_WIDE];
  logic [NUM_EVT-1:0] clr_vec;
  logic [5:0]         evi;
  logic [1:0]         hsl;

  always_comb begin
    evi = 6'(word_evt(int'(word)));
    hsl = 2'(high_slot(int'(word)));
    for (int e = 0; e < NUM_EVT; e++)
      clr_vec[e] = sel && (kind == WK_PLAIN || kind == WK_LOW) && (evi == 6'(e));
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    if (evt_is_wide(e)) begin : g_wide
      logic [2*CNT_W-1:0] full;
      stat_counter #(.W(2*CNT_W), .AMT_W(LEN_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (clr_vec[e]),
        .inc (evt[e]),
        .amt ((e == EV_TX_BYTES) ? tx_len : rx_len),
        .cnt (full)
      );
      assign lo_val[e]               = full[CNT_W-1:0];
      assign wide_hi[wide_slot(e)]   = full[2*CNT_W-1:CNT_W];
    end else begin : g_plain
      stat_counter #(.W(CNT_W), .AMT_W(1)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (clr_vec[e]),
        .inc (evt[e]),
        .amt (1'b1),
        .cnt (lo_val[e])
      );
    end
  end

  for (genvar s = 0; s < NUM_WIDE; s++) begin : g_hold
    localparam int EV = slot_evt(s);
    always_ff @(posedge clk) begin
      if (rst)              hi_lat[s] <= '0;
      else if (clr_vec[EV]) hi_lat[s] <= wide_hi[s];
    end
  end

  always_comb begin
    rd_word = '0;
    case (kind)
      WK_PLAIN, WK_LOW: if (evi < 6'(NUM_EVT)) rd_word = DATA_W'(lo_val[evi]);
      WK_HIGH:          if (hsl < 2'(NUM_WIDE)) rd_word = DATA_W'(hi_lat[hsl]);
      default:          rd_word = '0;
    endcase
  end

endmodule

// File: rtl/stat_bank.sv
module stat_bank #(
  parameter int NUM_PORTS = 6,
  parameter int CNT_W     = 32,
  parameter int LEN_W     = 16,
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 32,
  parameter int BASE_PAGE = 'h200
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NUM_PORTS*stat_pkg::NUM_EVT-1:0] evt_i,
  input  logic [NUM_PORTS*LEN_W-1:0]             rx_len_i,
  input  logic [NUM_PORTS*LEN_W-1:0]             tx_len_i,
  input  logic                                   rd_en_i,
  input  logic [ADDR_W-1:0]                      rd_addr_i,
  output logic                                   rd_valid_o,
  output logic [DATA_W-1:0]                      rd_data_o
);
  import stat_pkg::*;

  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic              hit;
  logic [PORT_W-1:0] port;
  logic [5:0]        word;
  word_kind_e        kind;
  logic [DATA_W-1:0] bank_word [NUM_PORTS];
  logic [DATA_W-1:0] sel_word;

  stat_addr_dec #(
    .ADDR_W    (ADDR_W),
    .BASE_PAGE (BASE_PAGE),
    .NUM_PORTS (NUM_PORTS)
  ) u_dec (
    .addr (rd_addr_i),
    .hit  (hit),
    .port (port),
    .word (word),
    .kind (kind)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    stat_port_bank #(
      .CNT_W  (CNT_W),
      .LEN_W  (LEN_W),
      .DATA_W (DATA_W)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt_i[p*NUM_EVT +: NUM_EVT]),
      .rx_len  (rx_len_i[p*LEN_W +: LEN_W]),
      .tx_len  (tx_len_i[p*LEN_W +: LEN_W]),
      .sel     (rd_en_i && hit && (port == PORT_W'(p))),
      .word    (word),
      .kind    (kind),
      .rd_word (bank_word[p])
    );
  end

  always_comb begin
    sel_word = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (hit && (port == PORT_W'(p))) sel_word = sel_word | bank_word[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      rd_data_o  <= (rd_en_i && hit) ? sel_word : '0;
    end
  end

endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
  parameter int NUM_PORTS = 6,
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 32,
  parameter int BASE_PAGE = 'h200,
  parameter int EVT_W     = 234
) (
  input logic              clk,
  input logic              rst,
  input logic [EVT_W-1:0]  evt_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W:0] LO_ADDR = (ADDR_W+1)'(BASE_PAGE * 256);
  localparam logic [ADDR_W:0] HI_ADDR = (ADDR_W+1)'((BASE_PAGE + NUM_PORTS) * 256);
  localparam logic [7:0]      LAST    = 8'((stat_pkg::NUM_WORDS - 1) * 4);

  logic mapped;
  logic upper;

  always_comb begin
    mapped = (rd_addr_i[1:0] == 2'b00) && ({1'b0, rd_addr_i} >= LO_ADDR) &&
             ({1'b0, rd_addr_i} < HI_ADDR) && (rd_addr_i[7:0] <= LAST);
    upper  = (rd_addr_i[7:0] == 8'h40) || (rd_addr_i[7:0] == 8'h48) ||
             (rd_addr_i[7:0] == 8'h88);
  end

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!rd_valid_o && rd_data_o == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);

  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_valid_o);

  assert_idle_data_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> rd_data_o == '0);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !mapped) |=> rd_data_o == '0);

  assert_reread_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && mapped && !upper && $past(rd_en_i) &&
     rd_addr_i == $past(rd_addr_i) && $past(evt_i) == '0) |=> rd_data_o == '0);

endmodule

bind stat_bank stat_bank_chk #(
  .NUM_PORTS (NUM_PORTS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .BASE_PAGE (BASE_PAGE),
  .EVT_W     (NUM_PORTS*stat_pkg::NUM_EVT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_i      (evt_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/sim_stat_bank.sv
module sim_stat_bank;
  localparam int NP = 6;
  localparam int CW = 8;
  localparam int LW = 8;
  localparam int AW = 18;
  localparam int DW = 32;
  localparam int NE = 39;
  localparam int NW = 42;
  localparam longint unsigned CMASK = (64'd1 << CW) - 1;
  localparam longint unsigned WMASK = (64'd1 << (2*CW)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NP*NE-1:0] ev;
  logic [NP*LW-1:0] rxl, txl;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;
  logic             rd_valid;
  logic [DW-1:0]    rd_data;

  stat_bank #(
    .NUM_PORTS (NP), .CNT_W (CW), .LEN_W (LW), .ADDR_W (AW), .DATA_W (DW)
  ) u0 (
    .clk (clk), .rst (rst), .evt_i (ev), .rx_len_i (rxl), .tx_len_i (txl),
    .rd_en_i (rd_en), .rd_addr_i (rd_addr), .rd_valid_o (rd_valid), .rd_data_o (rd_data)
  );

  int checks = 0;
  int errors = 0;
  longint unsigned m_cnt [NP][NE];
  longint unsigned m_hi  [NP][3];

  function automatic int w_of(int e);
    return e + int'(e > 15) + int'(e > 16) + int'(e > 31);
  endfunction

  function automatic int wslot(int e);
    if (e == 15) return 0;
    if (e == 16) return 1;
    if (e == 31) return 2;
    return -1;
  endfunction

  function automatic logic [AW-1:0] adr(int p, int w);
    return AW'(32'h20000 + p*256 + w*4);
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit rd, input logic [AW-1:0] a, input string tag_in);
    longint unsigned exp, full, amt, mx;
    string tag;
    int p, w, e, hs;
    bit ok;
    @(negedge clk);
    rd_en = rd;
    rd_addr = a;
    exp = 0;
    tag = tag_in;
    if (rd) begin
      ok = (a[1:0] == 2'b00) && (a >= AW'(32'h20000)) &&
           (a < AW'(32'h20000 + NP*256)) && (a[7:0] <= 8'hA4);
      p = int'((a - AW'(32'h20000)) >> 8);
      w = int'(a[7:2]);
      hs = (w == 16) ? 0 : (w == 18) ? 1 : (w == 34) ? 2 : -1;
      if (!ok) begin
        if (tag == "") tag = "R9";
      end else if (hs >= 0) begin
        exp = m_hi[p][hs];
        if (tag == "") tag = "R8";
      end else begin
        e = w - int'(w > 16) - int'(w > 18) - int'(w > 34);
        full = m_cnt[p][e];
        exp = full & CMASK;
        if (wslot(e) >= 0) m_hi[p][wslot(e)] = full >> CW;
        if (tag == "") begin
          if (ev[p*NE+e])                                   tag = "R6";
          else if (full == ((wslot(e) >= 0) ? WMASK : CMASK)) tag = "R7";
          else if (full == 0)                               tag = "R5";
          else if (wslot(e) >= 0)                           tag = "R4";
          else                                              tag = "R3";
        end
        m_cnt[p][e] = 0;
      end
    end
    for (int q = 0; q < NP; q++)
      for (int k = 0; k < NE; k++)
        if (ev[q*NE+k]) begin
          if (wslot(k) >= 0) begin
            amt = (k == 31) ? longint'(txl[q*LW +: LW]) : longint'(rxl[q*LW +: LW]);
            mx = WMASK;
          end else begin
            amt = 1;
            mx = CMASK;
          end
          m_cnt[q][k] = m_cnt[q][k] + amt;
          if (m_cnt[q][k] > mx) m_cnt[q][k] = mx;
        end
    @(posedge clk);
    #1;
    chk("R2", longint'(rd_valid), longint'(rd));
    chk(rd ? tag : "R2", longint'(rd_data), exp);
  endtask

  task automatic pulse(int p, int e, int len, int k);
    for (int i = 0; i < k; i++) begin
      ev = '0;
      ev[p*NE+e] = 1'b1;
      rxl[p*LW +: LW] = LW'(len);
      txl[p*LW +: LW] = LW'(len);
      step(1'b0, '0, "");
    end
    ev = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ev = '0; rxl = '0; txl = '0; rd_en = 1'b0; rd_addr = '0;
    for (int p = 0; p < NP; p++) begin
      for (int e = 0; e < NE; e++) m_cnt[p][e] = 0;
      for (int s = 0; s < 3; s++) m_hi[p][s] = 0;
    end
    repeat (4) @(posedge clk);
    #1;
    chk("R10", longint'(rd_valid), 0);
    chk("R10", longint'(rd_data), 0);
    @(negedge clk);
    rst = 1'b0;

    // R10: every word of port 0 starts at zero
    for (int w = 0; w < NW; w++) step(1'b1, adr(0, w), "R10");

    // R1 / R3 / R4 / R8 / R5 / R9 / R11: sweep every event of every port
    for (int p = 0; p < NP; p++) begin
      for (int e = 0; e < NE; e++) begin
        pulse(p, e, 200 + e, (e % 4) + 1);
        step(1'b1, adr(p, w_of(e)) + AW'(1), "R9");
        step(1'b1, adr(p, w_of(e)), "R1");
        if (wslot(e) >= 0) step(1'b1, adr(p, w_of(e) + 1), "R8");
        step(1'b1, adr(p, w_of(e)), "R5");
        step(1'b1, adr((p + 1) % NP, w_of(e)), "R11");
      end
      for (int w = 0; w < 64; w++) step(1'b1, adr(p, w), "");
    end

    // R9: pages outside the map
    step(1'b1, AW'(32'h1FF00), "R9");
    step(1'b1, adr(NP, 0), "R9");
    step(1'b1, adr(NP + 1, 3), "R9");

    // R7: saturation of a frame counter and of a byte total
    pulse(3, 0, 1, 300);
    step(1'b1, adr(3, 0), "R7");
    pulse(4, 31, 255, 300);
    step(1'b1, adr(4, 33), "R7");
    step(1'b1, adr(4, 34), "R8");

    // R6: read and strobe on the same counter in the same cycle
    pulse(1, 5, 1, 3);
    ev = '0; ev[1*NE+5] = 1'b1;
    step(1'b1, adr(1, 5), "R6");
    ev = '0;
    step(1'b1, adr(1, 5), "R6");
    pulse(2, 16, 40, 2);
    ev = '0; ev[2*NE+16] = 1'b1; rxl[2*LW +: LW] = LW'(9);
    step(1'b1, adr(2, 17), "R6");
    ev = '0;
    step(1'b1, adr(2, 17), "R6");

    // random collisions across all ports and addresses
    begin
      logic [AW-1:0] last_a;
      last_a = adr(0, 0);
      for (int n = 0; n < 3000; n++) begin
        logic [AW-1:0] a;
        for (int i = 0; i < NP*NE; i++) ev[i] = (($urandom % 8) == 0);
        for (int i = 0; i < NP; i++) begin
          rxl[i*LW +: LW] = LW'($urandom);
          txl[i*LW +: LW] = LW'($urandom);
        end
        if (($urandom % 4) == 0) a = last_a;
        else a = AW'(32'h20000 + ($urandom % 8) * 256 + ($urandom % 64) * 4 +
                      ((($urandom % 16) == 0) ? 2 : 0));
        last_a = a;
        step(1'(($urandom % 2)), a, "");
      end
      ev = '0;
      for (int p = 0; p < NP; p++)
        for (int w = 0; w < NW; w++) step(1'b1, adr(p, w), "");
    end

    step(1'b0, '0, "R2");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule